// File: doc/BRIEF.md
# Synchronous Serial Position Slave with Retriggerable Monoflop

This block sends a position word to a controller over a synchronous serial link. The controller drives the serial clock, and the block answers on a single data line. The serial clock idles high. The first falling edge seen while the link is idle captures the current position. Each later rising edge puts out one bit, most significant bit first. A retriggerable monoflop frames the transfer. Every clock edge during a transfer restarts it. When no edge arrives for the timeout period, the data line goes back high and the link is idle again.

The word length follows a resolution code, so a coarser setting sends fewer bits. The upper bits of the position are sent. A 2-bit mode selects what happens when the controller keeps clocking after the last bit:
- In the single modes the line stays low until the timeout.
- In the repeat mode the same word is sent again after one zero bit.
- In the refresh mode a newly captured word is sent after one zero bit.

The serial clock is asynchronous to the system clock. It passes through a synchronizer before its edges are detected. The timeout is counted in system clock cycles.

Top module: `ssi_pos_slave`

## Requirements
- R1: After reset, and whenever the monoflop is not running, `data_o` is 1. The monoflop expires MONO_CYCLES system cycles after the last serial clock edge of a transfer, and `data_o` then returns to 1.
- R2: A falling edge of `ssi_clk_i` while idle captures `pos_i`, `res_i` and `mode_i` and starts the monoflop. `data_o` stays 1 until the first rising edge.
- R3: The k-th rising edge of a word (k from 0) drives `data_o` with captured position bit POS_W-1-k. Falling edges inside a word leave `data_o` unchanged.
- R4: The word length is POS_W minus the value of `res_i`. With POS_W=12, code 0 gives 12 bits, code 3 gives 9 bits and code 7 gives 5 bits.
- R5: The falling edge after the last bit drives `data_o` to 0. In mode 2'b00, extra rising edges keep it at 0 until the timeout.
- R6: During a transfer, every edge of either polarity restarts the monoflop. A transfer longer than MONO_CYCLES therefore does not expire while edges keep arriving closer together than MONO_CYCLES.
- R7: In mode 2'b10, the rising edge after the last bit outputs one 0. The following rising edges resend the same captured word, and this repeats for as long as clocking continues.
- R8: In mode 2'b11, the rising edge after the last bit outputs one 0 and captures `pos_i` again. The following rising edges send that new word.
- R9: Mode 2'b01 behaves exactly like mode 2'b00.
- R10: A change of `pos_i` after the capture does not change the word being sent in modes 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ssi_clk_i | input | 1 | Serial clock from the controller, idles high, asynchronous |
| pos_i | input | POS_W | Current position, natural binary |
| res_i | input | RES_W | Resolution code; word length is POS_W minus this value |
| mode_i | input | 2 | 00/01 single, 10 repeat, 11 refresh |
| data_o | output | 1 | Serial data line |

## Verification
The bench reads positions with alternating, clustered and sparse bit patterns at 12, 9 and 5 bit lengths, so that a wrong bit order or a wrong length shows up as a mismatched bit. Each run clocks beyond the word. This separates the single modes, which hold the line low, from the repeat mode, which resends the old word after one zero, and from the refresh mode, which sends the position applied after capture. Changing the position right after capture shows whether the word is held or refreshed. The data line is checked both just before and after the timeout. This shows that every edge restarts the monoflop and that the line returns high on expiry.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    SSI_ONCE     = 2'b00,
    SSI_ONCE_ALT = 2'b01,
    SSI_REPEAT   = 2'b10,
    SSI_REFRESH  = 2'b11
  } ssi_mode_e;

  function automatic logic mode_is_ring(ssi_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/ssi_edge_det.sv
module ssi_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  // idle-high line: reset every stage to 1
  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b1;
        else         chain_q[0] <= line_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ssi_monoflop.sv
module ssi_monoflop #(
  parameter int unsigned MONO_CYCLES = 200,
  localparam int unsigned CNT_W = $clog2(MONO_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             trig_o,
  output logic             active_o,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign active_o = (cnt_q != '0);
  // idle: only a falling edge starts; running: any edge restarts
  assign trig_o   = fall_i | (rise_i & active_o);
  assign expire_o = (cnt_q == CNT_W'(1)) & ~trig_o;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (trig_o)    cnt_q <= CNT_W'(MONO_CYCLES);
    else if (active_o)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter
  import ssi_pkg::*;
#(
  parameter int unsigned POS_W = 12,
  parameter int unsigned RES_W = 3,
  localparam int unsigned IDX_W = $clog2(POS_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             active_i,
  input  logic             expire_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [1:0]       mode_i,
  output logic             data_o
);
  logic [POS_W-1:0] word_q, sh_q;
  logic [IDX_W-1:0] idx_q, len_q;
  ssi_mode_e        mode_q;
  logic             data_q;
  logic             at_end;

  assign at_end = (idx_q == len_q);
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      len_q  <= IDX_W'(POS_W);
      mode_q <= SSI_ONCE;
      data_q <= 1'b1;
    end else if (!active_i) begin
      if (fall_i) begin
        word_q <= pos_i;
        sh_q   <= pos_i;
        idx_q  <= '0;
        len_q  <= IDX_W'(POS_W) - IDX_W'(res_i);
        mode_q <= ssi_mode_e'(mode_i);
      end
    end else if (expire_i) begin
      data_q <= 1'b1;
      idx_q  <= '0;
    end else if (rise_i) begin
      if (!at_end) begin
        data_q <= sh_q[POS_W-1];
        sh_q   <= sh_q << 1;
        idx_q  <= idx_q + IDX_W'(1);
      end else begin
        data_q <= 1'b0;
        if (mode_is_ring(mode_q)) begin
          idx_q <= '0;
          if (mode_q == SSI_REFRESH) begin
            word_q <= pos_i;
            sh_q   <= pos_i;
          end else begin
            sh_q <= word_q;
          end
        end
      end
    end else if (fall_i && at_end) begin
      data_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ssi_pos_slave.sv
module ssi_pos_slave #(
  parameter int unsigned POS_W       = 12,
  parameter int unsigned RES_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MONO_CYCLES = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ssi_clk_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [1:0]       mode_i,
  output logic             data_o
);
  localparam int unsigned CNT_W = $clog2(MONO_CYCLES + 1);

  logic             edge_rise, edge_fall;
  logic             mono_trig, mono_active, mono_expire;
  logic [CNT_W-1:0] mono_cnt;

  ssi_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .line_i(ssi_clk_i),
    .rise_o(edge_rise), .fall_o(edge_fall)
  );

  ssi_monoflop #(.MONO_CYCLES(MONO_CYCLES)) u_mono (
    .clk_i, .rst_ni, .rise_i(edge_rise), .fall_i(edge_fall),
    .trig_o(mono_trig), .active_o(mono_active),
    .expire_o(mono_expire), .cnt_o(mono_cnt)
  );

  ssi_shifter #(.POS_W(POS_W), .RES_W(RES_W)) u_shift (
    .clk_i, .rst_ni, .rise_i(edge_rise), .fall_i(edge_fall),
    .active_i(mono_active), .expire_i(mono_expire),
    .pos_i, .res_i, .mode_i, .data_o
  );
endmodule

// File: rtl/ssi_pos_slave_chk.sv
module ssi_pos_slave_chk #(
  parameter int unsigned MONO_CYCLES = 200,
  localparam int unsigned CNT_W = $clog2(MONO_CYCLES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_o,
  input logic             rise,
  input logic             fall,
  input logic             trig,
  input logic             active,
  input logic             expire,
  input logic [CNT_W-1:0] cnt
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> data_o);

  a_r1_expire_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (data_o && !active));

  a_r2_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && fall) |=> (data_o && active));

  a_r3_hold_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !rise && !fall && !expire) |=> $stable(data_o));

  a_r6_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && (rise || fall)) |=> (cnt == CNT_W'(MONO_CYCLES)));

  a_r6_trig_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |-> (rise || fall));
endmodule

bind ssi_pos_slave ssi_pos_slave_chk #(.MONO_CYCLES(MONO_CYCLES)) u_chk (
  .clk_i, .rst_ni, .data_o,
  .rise(edge_rise), .fall(edge_fall), .trig(mono_trig),
  .active(mono_active), .expire(mono_expire), .cnt(mono_cnt)
);

// File: tb/ssi_pos_slave_bench.sv
module ssi_pos_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MONO = 100;
  localparam int POS_W = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ssi_clk_i = 1'b1;
  logic [11:0] pos_i = '0;
  logic [2:0]  res_i = '0;
  logic [1:0]  mode_i = '0;
  logic        data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ssi_pos_slave #(.POS_W(POS_W), .RES_W(3), .SYNC_STAGES(2), .MONO_CYCLES(MONO))
    u_ssi_pos_slave (.clk_i, .rst_ni, .ssi_clk_i, .pos_i, .res_i, .mode_i, .data_o);

  // monitor: pops expected items and compares with the line
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (data_o !== e) begin
        errors++;
        $display("FAIL %s: data_o=%b expected %b", t, data_o, e);
      end
    end
  end

  task automatic expect_bit(logic e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // one half period of the serial clock, then a sample
  task automatic half(logic v, logic e, string t);
    @(negedge clk_i);
    ssi_clk_i = v;
    repeat (6) @(negedge clk_i);
    expect_bit(e, t);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic xfer(int res, logic [1:0] mode, logic [11:0] pa, logic [11:0] pb,
                      int nrise, string t);
    int   len;
    bit   ring;
    logic prev;
    int   jprev;
    len  = POS_W - res;
    ring = mode[1];
    res_i = 3'(res);
    mode_i = mode;
    pos_i = pa;
    half(1'b0, 1'b1, "R2 high before first rise");
    pos_i = pb;
    prev  = 1'b1;
    jprev = -1;
    for (int k = 0; k < nrise; k++) begin
      int    p, j;
      logic  e;
      logic [11:0] w;
      string tt;
      if (k > 0) half(1'b0, (jprev == len - 1) ? 1'b0 : prev, "R3 R5 fall edge");
      p = k / (len + 1);
      j = k % (len + 1);
      if (!ring) begin
        e  = (k < len) ? pa[11-k] : 1'b0;
        tt = (k < len) ? t : "R5 low after word";
        j  = (k < len) ? k : len;
      end else if (j == len) begin
        e  = 1'b0;
        tt = (mode == 2'b11) ? "R8 separator" : "R7 separator";
      end else begin
        w  = (p > 0 && mode == 2'b11) ? pb : pa;
        e  = w[11-j];
        tt = (p == 0) ? t : ((mode == 2'b11) ? "R8 fresh word" : "R7 repeated word");
      end
      half(1'b1, e, tt);
      prev  = e;
      jprev = j;
    end
    repeat (MONO - 40) @(negedge clk_i);
    expect_bit(prev, "R6 no expiry before timeout");
    repeat (62) @(negedge clk_i);
    expect_bit(1'b1, "R1 high after timeout");
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    expect_bit(1'b1, "R1 reset idle high");
    repeat (2) @(negedge clk_i);

    xfer(0, 2'b00, 12'hA5C, 12'h3C3, 14, "R3 R4 R10 12-bit word");
    xfer(3, 2'b00, 12'h9F0, 12'h60F, 11, "R4 9-bit word");
    xfer(7, 2'b01, 12'hB7F, 12'h000, 7,  "R9 R4 5-bit word");
    xfer(4, 2'b10, 12'h6A5, 12'h111, 21, "R7 R10 first word");
    xfer(2, 2'b11, 12'h5A3, 12'hC3C, 25, "R8 first word");

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule